// File: doc/BRIEF.md
# Host Bus Quadlet Register Bridge

This block lets a simple strobe-based microcontroller bus reach a bank of 32-bit registers inside a chip. The host bus is either 8 or 16 bits wide, and its address arrives either on dedicated address lines or time-shared with the low data byte and captured by an address latch enable. Since the host moves one byte or one 16-bit word per access, the bridge keeps two 32-bit staging latches. Writes assemble a quadlet lane by lane. Reads deliver lanes out of a quadlet that was captured earlier.

An extra control address bit decides when a whole quadlet moves between a staging latch and the register bank. On a read it is set with the first lane, which copies the addressed register into the read latch. On a write it is set with the last lane, which commits the assembled write latch to the addressed register. Strobes pass through two-flop synchronizers, and each access acts once, on the falling edge of its strobe. A busy output stays high for a fixed number of internal cycles after each quadlet transfer. Register 0 holds sticky interrupt flags, and the active-low interrupt request follows them.

Top module: `hostq_bridge`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it is released, every register, both staging latches and the wait counter are zero. So the read data outputs are zero, `wait_o` is low and `irq_n` is high.
- R2: A read with `ctl_a8`=1 loads the addressed register into the read latch. A read with `ctl_a8`=0 only returns a lane of the read latch as it already stands, even if the register has changed since it was loaded.
- R3: A write with `ctl_a8`=0 only updates one lane of the write latch, and no register changes. A write with `ctl_a8`=1 merges its lane into the latch and then stores the full 32-bit latch into the addressed register.
- R4: With `mode_wide`=0 the lane is address bits [1:0] in big-endian order (0 selects bits 31:24, 3 selects bits 7:0). Data uses `din_lo` and `dout_lo` only. `din_hi` is ignored and `dout_hi` reads 0.
- R5: With `mode_wide`=1 address bit 1 selects the half (0 selects bits 31:16, 1 selects bits 15:0), with bits 31:24 or 15:8 on the upper byte lane. Address bit 0 is ignored.
- R6: While `cs_n` is high no access takes place, whatever the strobes do: the latches and registers keep their values and `wait_o` stays low.
- R7: When `cs_n`, `wr_n` and `rd_n` are all low, the access is a write. The read latch is not reloaded.
- R8: Every quadlet transfer (a fetch or a store) drives `wait_o` high for exactly WAIT_CYC clock cycles, starting on the cycle after the transfer commits. Lane-only accesses leave `wait_o` low.
- R9: With `mode_mux`=1 the access address is the value on `din_lo` captured while `ale` is high, and `addr_lo` is ignored. With `mode_mux`=0 the address is `addr_lo`.
- R10: Register 0 holds IRQ_W sticky flags, which are set by the `irq_set` bits one cycle later. Storing to register 0 clears every flag whose data bit is 1. `irq_n` is low whenever any flag is set, and reading register 0 returns the flags in the low bits with zeros above them.
- R11: The register index is address bits [IDX_W+1:2]. Higher address bits are ignored, and each register holds its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wide | input | 1 | 0: 8-bit host data, 1: 16-bit host data |
| mode_mux | input | 1 | 1: address is taken from the data lines with `ale` |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| ale | input | 1 | Address latch enable, active high |
| addr_lo | input | 8 | Dedicated address lines |
| ctl_a8 | input | 1 | Quadlet transfer control bit |
| din_lo | input | 8 | Host data in, low byte lane; also carries the address in multiplexed mode |
| din_hi | input | 8 | Host data in, high byte lane |
| dout_lo | output | 8 | Host read data, low byte lane |
| dout_hi | output | 8 | Host read data, high byte lane |
| wait_o | output | 1 | High while a quadlet transfer is in progress |
| irq_set | input | IRQ_W | Interrupt flag set pulses |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the bridge with NUM_REGS=4, WAIT_CYC=2 and IRQ_W=8. With that configuration it can sweep every register index against every lane, in both bus widths and both address modes, and each sweep point ends with a full write and a full read-back. The small index field also lets the bench put junk in the high address bits and, in multiplexed mode, put a wrong index on the dedicated address lines. The short wait window lets every access be checked for its exact count of busy cycles.

// File: rtl/hqb_pkg.sv
package hqb_pkg;

  typedef logic [31:0] quad_t;

  // Replace one host lane of a quadlet, big-endian lane order.
  function automatic quad_t lane_merge(quad_t q, logic wide, logic [1:0] lane,
                                       logic [15:0] d);
    quad_t r;
    int    b;
    r = q;
    b = 3 - int'(lane);
    if (wide) begin
      if (lane[1]) r[15:0]  = d;
      else         r[31:16] = d;
    end else begin
      r[b*8 +: 8] = d[7:0];
    end
    return r;
  endfunction

  // Extract one host lane of a quadlet; upper byte is zero in 8-bit mode.
  function automatic logic [15:0] lane_pick(quad_t q, logic wide, logic [1:0] lane);
    logic [15:0] r;
    int          b;
    b = 3 - int'(lane);
    if (wide) r = lane[1] ? q[15:0] : q[31:16];
    else      r = {8'h00, q[b*8 +: 8]};
    return r;
  endfunction

endpackage

// File: rtl/hqb_sync.sv
module hqb_sync #(
  parameter int           W       = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

endmodule

// File: rtl/hqb_decode.sv
module hqb_decode #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          wr_s,
  input  logic          rd_s,
  input  logic          ale_s,
  input  logic          mux,
  input  logic [AW-1:0] addr_lo,
  input  logic [AW-1:0] din_lo,
  input  logic          a8,
  output logic          wr_go,
  output logic          store_go,
  output logic          fetch_go,
  output logic [AW-1:0] eff_addr
);

  logic          wr_act, rd_act;
  logic          wr_prev_q, rd_prev_q;
  logic          rd_go;
  logic [AW-1:0] al_q, al_d;

  // Write wins when both strobes are low.
  always_comb begin
    wr_act = !cs_s && !wr_s;
    rd_act = !cs_s && !rd_s && wr_s;
    wr_go  = wr_act && !wr_prev_q;
    rd_go  = rd_act && !rd_prev_q;
    store_go = wr_go && a8;
    fetch_go = rd_go && a8;
  end

  // Transparent address latch, enabled by the synchronized ALE.
  always_comb begin
    al_d = al_q;
    if (ale_s) al_d = din_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q <= 1'b0;
      rd_prev_q <= 1'b0;
      al_q      <= '0;
    end else begin
      wr_prev_q <= wr_act;
      rd_prev_q <= rd_act;
      al_q      <= al_d;
    end
  end

  assign eff_addr = mux ? al_q : addr_lo;

endmodule

// File: rtl/hqb_stage.sv
module hqb_stage
  import hqb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide,
  input  logic [1:0]  lane,
  input  logic [15:0] din,
  input  logic        wr_go,
  input  logic        fetch_go,
  input  quad_t       bank_rdata,
  output quad_t       wr_merge,
  output quad_t       wr_stage,
  output quad_t       rd_stage,
  output logic [15:0] dout
);

  quad_t wr_q, wr_d, rd_q, rd_d;

  always_comb begin
    wr_merge = lane_merge(wr_q, wide, lane, din);
    wr_d     = wr_go ? wr_merge : wr_q;
    rd_d     = fetch_go ? bank_rdata : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  assign wr_stage = wr_q;
  assign rd_stage = rd_q;
  assign dout     = lane_pick(rd_q, wide, lane);

endmodule

// File: rtl/hqb_regbank.sv
module hqb_regbank
  import hqb_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IRQ_W    = 8,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  quad_t            wdata,
  input  logic [IRQ_W-1:0] irq_set,
  output quad_t            rdata,
  output logic             irq_pend
);

  quad_t rd_vec [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == 0) begin : g_stat
      // Sticky flags: hardware set wins over host write-one-to-clear.
      logic [IRQ_W-1:0] st_q, st_d;
      always_comb begin
        st_d = st_q;
        if (we && idx == IDX_W'(i)) st_d = st_q & ~wdata[IRQ_W-1:0];
        st_d = st_d | irq_set;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
      end
      assign rd_vec[i] = {{(32-IRQ_W){1'b0}}, st_q};
      assign irq_pend  = |st_q;
    end else begin : g_rw
      quad_t q, d;
      always_comb begin
        d = q;
        if (we && idx == IDX_W'(i)) d = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign rd_vec[i] = q;
    end
  end

  assign rdata = rd_vec[idx];

endmodule

// File: rtl/hostq_bridge.sv
module hostq_bridge
  import hqb_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int WAIT_CYC = 2,
  parameter int IRQ_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wide,
  input  logic             mode_mux,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             ale,
  input  logic [7:0]       addr_lo,
  input  logic             ctl_a8,
  input  logic [7:0]       din_lo,
  input  logic [7:0]       din_hi,
  output logic [7:0]       dout_lo,
  output logic [7:0]       dout_hi,
  output logic             wait_o,
  input  logic [IRQ_W-1:0] irq_set,
  output logic             irq_n
);

  localparam int AW    = 8;
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int WC_W  = $clog2(WAIT_CYC + 1);

  // Reset: asynchronous assertion, synchronous release.
  logic rst_q1, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1    <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_q1    <= 1'b1;
      rst_int_n <= rst_q1;
    end
  end

  logic cs_s, wr_s, rd_s, ale_s;
  hqb_sync #(.W(4), .RST_VAL(4'b1110)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({cs_n, wr_n, rd_n, ale}),
    .q     ({cs_s, wr_s, rd_s, ale_s})
  );

  logic          wr_go, store_go, fetch_go;
  logic [AW-1:0] eff_addr;
  hqb_decode #(.AW(AW)) u_dec (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cs_s     (cs_s),
    .wr_s     (wr_s),
    .rd_s     (rd_s),
    .ale_s    (ale_s),
    .mux      (mode_mux),
    .addr_lo  (addr_lo),
    .din_lo   (din_lo),
    .a8       (ctl_a8),
    .wr_go    (wr_go),
    .store_go (store_go),
    .fetch_go (fetch_go),
    .eff_addr (eff_addr)
  );

  logic [IDX_W-1:0] reg_idx;
  logic [1:0]       lane;
  logic             unused_addr_bits;
  assign reg_idx          = eff_addr[IDX_W+1:2];
  assign lane             = eff_addr[1:0];
  assign unused_addr_bits = ^eff_addr;

  quad_t       bank_rdata, wr_merge, wr_stage, rd_stage;
  logic [15:0] dout;
  hqb_stage u_stage (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wide       (mode_wide),
    .lane       (lane),
    .din        ({din_hi, din_lo}),
    .wr_go      (wr_go),
    .fetch_go   (fetch_go),
    .bank_rdata (bank_rdata),
    .wr_merge   (wr_merge),
    .wr_stage   (wr_stage),
    .rd_stage   (rd_stage),
    .dout       (dout)
  );

  logic irq_pend;
  hqb_regbank #(.NUM_REGS(NUM_REGS), .IRQ_W(IRQ_W), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .we       (store_go),
    .idx      (reg_idx),
    .wdata    (wr_merge),
    .irq_set  (irq_set),
    .rdata    (bank_rdata),
    .irq_pend (irq_pend)
  );

  // Fixed busy window after each quadlet transfer.
  logic [WC_W-1:0] wcnt_q, wcnt_d;
  always_comb begin
    wcnt_d = wcnt_q;
    if (fetch_go || store_go) wcnt_d = WC_W'(WAIT_CYC);
    else if (wcnt_q != '0)    wcnt_d = wcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) wcnt_q <= '0;
    else            wcnt_q <= wcnt_d;
  end

  assign wait_o  = (wcnt_q != '0);
  assign dout_lo = dout[7:0];
  assign dout_hi = dout[15:8];
  assign irq_n   = ~irq_pend;

endmodule

// File: rtl/hostq_bridge_chk.sv
module hostq_bridge_chk #(
  parameter int WAIT_CYC = 2,
  parameter int IRQ_W    = 8
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             cs_n,
  input logic             wait_o,
  input logic             irq_n,
  input logic             fetch_go,
  input logic             store_go,
  input logic [IRQ_W-1:0] irq_set,
  input logic [31:0]      rd_stage,
  input logic [31:0]      wr_stage
);

  logic [1:0]  seen_q;
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)          seen_q <= '0;
    else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)                run_q <= '0;
    else if (fetch_go || store_go) run_q <= '0;
    else if (wait_o)               run_q <= run_q + 16'd1;
    else                           run_q <= '0;
  end

  // R2: the read latch changes only on the edge that commits a fetch
  p_rd_only_fetch_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (seen_q != 2'd0 && !$past(fetch_go)) |-> $stable(rd_stage));

  // R6: chip select high three samples earlier blocks any latch update
  p_cs_idle_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (seen_q == 2'd3 && $past(cs_n, 3)) |-> ($stable(rd_stage) && $stable(wr_stage)));

  // R8: busy follows every quadlet transfer
  p_wait_follows_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (seen_q != 2'd0 && $past(fetch_go || store_go)) |-> wait_o);

  // R8: busy never outlasts its window
  p_wait_bounded_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    wait_o |-> (run_q < 16'(WAIT_CYC)));

  // R10: a set pulse raises the interrupt request on the next cycle
  p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|irq_set) |=> !irq_n);

endmodule

bind hostq_bridge hostq_bridge_chk #(.WAIT_CYC(WAIT_CYC), .IRQ_W(IRQ_W)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .cs_n      (cs_n),
  .wait_o    (wait_o),
  .irq_n     (irq_n),
  .fetch_go  (fetch_go),
  .store_go  (store_go),
  .irq_set   (irq_set),
  .rd_stage  (rd_stage),
  .wr_stage  (wr_stage)
);

// File: tb/hostq_bridge_bench.sv
`timescale 1ns/1ps
module hostq_bridge_bench;

  localparam int NR = 4;
  localparam int WC = 2;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_wide, mode_mux, cs_n, wr_n, rd_n, ale, ctl_a8;
  logic [7:0]    addr_lo, din_lo, din_hi, dout_lo, dout_hi;
  logic          wait_o, irq_n;
  logic [IW-1:0] irq_set;

  hostq_bridge #(.NUM_REGS(NR), .WAIT_CYC(WC), .IRQ_W(IW)) u_hostq_bridge (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .mode_mux(mode_mux),
    .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .ale(ale), .addr_lo(addr_lo),
    .ctl_a8(ctl_a8), .din_lo(din_lo), .din_hi(din_hi), .dout_lo(dout_lo),
    .dout_hi(dout_hi), .wait_o(wait_o), .irq_set(irq_set), .irq_n(irq_n)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int wait_total = 0;

  logic [31:0] exp_reg [NR];
  logic [31:0] exp_wr, exp_rd;
  logic [7:0]  exp_stat;

  always @(posedge clk) if (wait_o === 1'b1) wait_total++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mput(logic [31:0] q, logic w, logic [1:0] ln, logic [15:0] d);
    int sh;
    logic [31:0] m;
    if (w) begin
      sh = ln[1] ? 0 : 16;
      m  = 32'h0000FFFF << sh;
      return (q & ~m) | ({16'h0, d} << sh);
    end
    sh = 24 - 8 * int'(ln);
    m  = 32'h000000FF << sh;
    return (q & ~m) | ({24'h0, d[7:0]} << sh);
  endfunction

  function automatic logic [15:0] mget(logic [31:0] q, logic w, logic [1:0] ln);
    int sh;
    logic [31:0] s;
    if (w) begin
      sh = ln[1] ? 0 : 16;
      s  = q >> sh;
      return s[15:0];
    end
    sh = 24 - 8 * int'(ln);
    s  = q >> sh;
    return {8'h00, s[7:0]};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NR; i++) exp_reg[i] = '0;
    exp_wr = '0; exp_rd = '0; exp_stat = '0;
  endtask

  task automatic acc(input string tag, input logic mux, input logic wide,
                     input logic [7:0] a, input logic a8, input logic wr,
                     input logic both, input logic csoff, input logic [15:0] d);
    int          w0, idx, expw;
    logic [1:0]  ln;
    logic [15:0] got;
    ln = a[1:0];
    idx = int'(a[3:2]);
    mode_mux = mux;
    mode_wide = wide;
    if (mux) begin
      din_lo = a;
      addr_lo = a ^ 8'h04;
      ale = 1'b1;
      repeat (4) @(negedge clk);
      ale = 1'b0;
      repeat (4) @(negedge clk);
    end else begin
      addr_lo = a;
    end
    ctl_a8 = a8;
    if (wr) {din_hi, din_lo} = d;
    w0 = wait_total;
    cs_n = csoff;
    if (wr) begin
      wr_n = 1'b0;
      rd_n = !both;
    end else begin
      rd_n = 1'b0;
    end
    repeat (8) @(negedge clk);
    expw = 0;
    if (!csoff) begin
      if (wr) begin
        exp_wr = mput(exp_wr, wide, ln, d);
        if (a8) begin
          expw = WC;
          if (idx == 0) exp_stat = exp_stat & ~exp_wr[7:0];
          else          exp_reg[idx] = exp_wr;
        end
      end else if (a8) begin
        expw = WC;
        exp_rd = (idx == 0) ? {24'h0, exp_stat} : exp_reg[idx];
      end
    end
    got = {dout_hi, dout_lo};
    chk(tag, {16'h0, got}, {16'h0, mget(exp_rd, wide, ln)});
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; ctl_a8 = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8", wait_total - w0, expw);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog (all requirements) act=timeout exp=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] p;
    string       tg;
    mode_wide = 0; mode_mux = 0; cs_n = 1; wr_n = 1; rd_n = 1; ale = 0;
    ctl_a8 = 0; addr_lo = 0; din_lo = 0; din_hi = 0; irq_set = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", {dout_hi, dout_lo}, 32'h0);
    chk("R1", {30'h0, wait_o, irq_n}, 32'h1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
    chk("R1", {dout_hi, dout_lo}, 32'h0);
    chk("R1", {30'h0, wait_o, irq_n}, 32'h1);

    // Sweep: both address modes, both widths, every data register, every lane.
    for (int m = 0; m < 2; m++) begin
      for (int w = 0; w < 2; w++) begin
        for (int r = 1; r < NR; r++) begin
          logic [3:0] junk;
          junk = 4'(m * 2 + w + 5);
          p = (r + 1) * 32'h11223344 + m * 32'h00000F0F + w * 32'h0000005A;
          tg = (m != 0) ? "R9" : ((w != 0) ? "R5" : "R4");
          if (w == 0) begin
            for (int ln = 0; ln < 4; ln++) begin
              logic [31:0] s;
              s = p >> (24 - 8 * ln);
              acc("R3", 1'(m), 1'b0, {junk, 2'(r), 2'(ln)}, ln == 3, 1'b1, 1'b0, 1'b0,
                  {8'hC3, s[7:0]});
            end
            for (int ln = 0; ln < 4; ln++)
              acc(tg, 1'(m), 1'b0, {junk, 2'(r), 2'(ln)}, ln == 0, 1'b0, 1'b0, 1'b0, 16'h0);
          end else begin
            acc("R3", 1'(m), 1'b1, {junk, 2'(r), 2'd0}, 1'b0, 1'b1, 1'b0, 1'b0, p[31:16]);
            acc("R3", 1'(m), 1'b1, {junk, 2'(r), 2'd3}, 1'b1, 1'b1, 1'b0, 1'b0, p[15:0]);
            acc(tg, 1'(m), 1'b1, {junk, 2'(r), 2'd1}, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
            acc(tg, 1'(m), 1'b1, {junk, 2'(r), 2'd2}, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
          end
          chk(tg, exp_reg[r], p);
        end
      end
    end

    // R11: each register keeps its own value
    for (int r = 1; r < NR; r++)
      acc("R11", 1'b0, 1'b1, {4'h0, 2'(r), 2'd0}, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);

    // R2: a read without the control bit does not reload the read latch
    acc("R2", 1'b0, 1'b0, 8'h04, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    acc("R3", 1'b0, 1'b1, 8'h04, 1'b0, 1'b1, 1'b0, 1'b0, 16'hBEEF);
    acc("R3", 1'b0, 1'b1, 8'h06, 1'b1, 1'b1, 1'b0, 1'b0, 16'hCAFE);
    acc("R2", 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    acc("R2", 1'b0, 1'b0, 8'h04, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R2", exp_rd, 32'hBEEFCAFE);

    // R3: lane writes alone leave the register untouched
    acc("R3", 1'b0, 1'b0, 8'h08, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0011);
    acc("R3", 1'b0, 1'b0, 8'h09, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0022);
    acc("R3", 1'b0, 1'b0, 8'h0A, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0033);
    acc("R3", 1'b0, 1'b0, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    acc("R3", 1'b0, 1'b0, 8'h0B, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0044);
    acc("R3", 1'b0, 1'b1, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R3", exp_reg[2], 32'h11223344);

    // R6: chip select high blocks the access
    acc("R6", 1'b0, 1'b0, 8'h0F, 1'b1, 1'b1, 1'b0, 1'b1, 16'h00EE);
    acc("R6", 1'b0, 1'b0, 8'h0C, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0);
    acc("R6", 1'b0, 1'b1, 8'h0E, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);

    // R7: both strobes low acts as a write
    acc("R7", 1'b0, 1'b0, 8'h04, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    acc("R7", 1'b0, 1'b0, 8'h0B, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0077);
    acc("R7", 1'b0, 1'b1, 8'h0A, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R7", exp_reg[2], 32'h11223377);

    // R10: sticky interrupt flags, write-one-to-clear
    @(negedge clk);
    irq_set = 8'h21;
    @(negedge clk);
    irq_set = 8'h00;
    exp_stat = 8'h21;
    @(negedge clk);
    chk("R10", {31'h0, irq_n}, 32'h0);
    acc("R10", 1'b0, 1'b0, 8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    acc("R10", 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF);
    acc("R10", 1'b0, 1'b1, 8'h02, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0001);
    chk("R10", {31'h0, irq_n}, 32'h0);
    acc("R10", 1'b0, 1'b1, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    acc("R10", 1'b0, 1'b1, 8'h02, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0020);
    chk("R10", {31'h0, irq_n}, 32'h1);
    acc("R10", 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);

    // R1: reset in mid-run clears everything
    do_reset();
    chk("R1", {dout_hi, dout_lo}, 32'h0);
    chk("R1", {30'h0, wait_o, irq_n}, 32'h1);
    acc("R1", 1'b0, 1'b1, 8'h04, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    acc("R1", 1'b0, 1'b1, 8'h06, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule